// File: doc/BRIEF.md
# Byte-Lane Configurable General-Purpose IO Port

This block is a 32-bit general-purpose digital port that a host reaches through simple register write and read strobes. Each byte of the port is either an output lane or an input lane, chosen by one direction bit per byte in a configuration register. Output lanes drive a latched value onto the pins with the matching output-enable bits set. Input lanes leave their pins undriven.

Input data can be captured in one of two ways. In internal mode, the port pins are sampled at the clock edge where a host read begins. In external mode, a separate strobe input marks when to capture. That strobe is passed through a two-flop synchroniser, and its rising edge turns into a single capture pulse in the system clock domain.

A read returns one 32-bit word built per lane. Output lanes give back the latched output value. Input lanes give back the sampled or captured input value.

Top module: `byte_dio`

## Requirements
- R1: While reset is asserted and after it is released, every lane is an input (`cfg_dir` = 0), internal mode is selected (`cfg_ext` = 0), and `pin_oe`, `pin_out` and `data_rdata` are all zero.
- R2: A `cfg_we` pulse loads `cfg_dir_wr` and `cfg_ext_wr`. From the following cycle, bit b of `cfg_dir` (1 = output) sets all eight bits `pin_oe[8b+7:8b]`.
- R3: A `data_we` pulse stores the bits of `data_wdata` that fall in output lanes. From the next cycle, those lanes of `pin_out` show the written value.
- R4: Bits of `data_wdata` that fall in input lanes are ignored. The output latch for those lanes keeps its previous value, and `pin_out` reads zero on every input lane.
- R5: In internal mode, a `data_re` pulse samples `pin_in` at that clock edge. From the next cycle, `data_rdata` holds the result on input lanes, and it keeps that result unchanged until the next `data_re`.
- R6: In external mode, `pin_in` is captured on the third rising clock edge after `ext_strobe` rises. Only a rising strobe causes a capture; a falling or steady strobe does not. Reads return this captured value on input lanes, not the live pins.
- R7: On output lanes, a read returns the output latch value.
- R8: Switching a lane's direction does not change its output latch. When the lane becomes an output again, it drives the value it held before. Without a data or configuration write, `pin_out` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dir_wr | input | 4 | New per-lane direction bits, 1 = output |
| cfg_ext_wr | input | 1 | New capture mode, 1 = external strobe |
| cfg_dir | output | 4 | Current lane directions |
| cfg_ext | output | 1 | Current capture mode |
| data_we | input | 1 | Data register write strobe |
| data_wdata | input | 32 | Data to write |
| data_re | input | 1 | Data register read strobe |
| data_rdata | output | 32 | Read result, valid the cycle after `data_re` |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables |
| pin_in | input | 32 | Pin input values |
| ext_strobe | input | 1 | Asynchronous external capture strobe |

## Verification
Configuration and data writes take effect at the clock edge of their strobe, and `cfg_dir`, `pin_oe` and `pin_out` are checked one cycle after that edge. A read result appears in `data_rdata` one cycle after `data_re`. The external-mode test changes `pin_in` just before and just after the third edge following the strobe rise, which confirms exactly which edge does the capture. Every input is driven, and every output is sampled, on the falling clock edge, so each check lands in the cycle after the edge that updates the result.

// File: rtl/byte_dio.sv
module byte_dio #(
  parameter int WIDTH = 32,
  localparam int LANES = WIDTH / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [LANES-1:0] cfg_dir_wr,
  input  logic             cfg_ext_wr,
  output logic [LANES-1:0] cfg_dir,
  output logic             cfg_ext,
  input  logic             data_we,
  input  logic [WIDTH-1:0] data_wdata,
  input  logic             data_re,
  output logic [WIDTH-1:0] data_rdata,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  input  logic [WIDTH-1:0] pin_in,
  input  logic             ext_strobe
);
  logic [LANES-1:0] dir_q;
  logic             ext_q;
  logic [WIDTH-1:0] out_q, in_q, rd_q, lane_mask;
  logic [2:0]       strb_q;
  logic             strb_rise;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_mask[g*8 +: 8] = {8{dir_q[g]}};
  end

  assign strb_rise = strb_q[1] & ~strb_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      ext_q  <= 1'b0;
      out_q  <= '0;
      in_q   <= '0;
      rd_q   <= '0;
      strb_q <= '0;
    end else begin
      strb_q <= {strb_q[1:0], ext_strobe};
      if (cfg_we) begin
        dir_q <= cfg_dir_wr;
        ext_q <= cfg_ext_wr;
      end
      if (data_we)
        out_q <= (out_q & ~lane_mask) | (data_wdata & lane_mask);
      if (ext_q ? strb_rise : data_re)
        in_q <= pin_in;
      if (data_re)
        rd_q <= (out_q & lane_mask) | ((ext_q ? in_q : pin_in) & ~lane_mask);
    end
  end

  assign cfg_dir    = dir_q;
  assign cfg_ext    = ext_q;
  assign pin_oe     = lane_mask;
  assign pin_out    = out_q & lane_mask;
  assign data_rdata = rd_q;
endmodule

// File: rtl/byte_dio_chk.sv
module byte_dio_chk #(
  parameter int WIDTH = 32,
  localparam int LANES = WIDTH / 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic             cfg_ext,
  input logic             data_we,
  input logic [WIDTH-1:0] data_wdata,
  input logic             data_re,
  input logic [WIDTH-1:0] data_rdata,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_oe,
  input logic [WIDTH-1:0] pin_in
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == '0 && pin_out == '0 && data_rdata == '0));

  assert_pins_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_we && !cfg_we) |=> $stable(pin_out));

  assert_read_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !data_re |=> $stable(data_rdata));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assert_out_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (data_we && !cfg_we && pin_oe[g*8]) |=> pin_out[g*8 +: 8] == $past(data_wdata[g*8 +: 8]));
    assert_rd_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (data_re && pin_oe[g*8]) |=> data_rdata[g*8 +: 8] == $past(pin_out[g*8 +: 8]));
    assert_rd_int_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (data_re && !cfg_ext && !pin_oe[g*8]) |=> data_rdata[g*8 +: 8] == $past(pin_in[g*8 +: 8]));
  end
endmodule

bind byte_dio byte_dio_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ext(cfg_ext),
  .data_we(data_we), .data_wdata(data_wdata), .data_re(data_re),
  .data_rdata(data_rdata), .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in)
);

// File: tb/byte_dio_tb_top.sv
`timescale 1ns/1ps
module byte_dio_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 0, cfg_ext_wr = 0, data_we = 0, data_re = 0, ext_strobe = 0;
  logic [3:0]  cfg_dir_wr = '0, cfg_dir;
  logic        cfg_ext;
  logic [31:0] data_wdata = '0, data_rdata, pin_out, pin_oe, pin_in = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  byte_dio dut_i (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(logic [3:0] dir, logic ext);
    @(negedge clk); cfg_we = 1; cfg_dir_wr = dir; cfg_ext_wr = ext;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic wr(logic [31:0] v);
    @(negedge clk); data_we = 1; data_wdata = v;
    @(negedge clk); data_we = 0;
  endtask

  task automatic rd(output logic [31:0] v);
    @(negedge clk); data_re = 1;
    @(negedge clk); data_re = 0; v = data_rdata;
  endtask

  task automatic t_reset;
    check("R1 pin_oe", pin_oe, 0);
    check("R1 pin_out", pin_out, 0);
    check("R1 rdata", data_rdata, 0);
    check("R1 cfg", {27'd0, cfg_ext, cfg_dir}, 0);
  endtask

  task automatic t_dir_and_write;
    cfg(4'b0101, 0);
    check("R2 cfg_dir", {28'd0, cfg_dir}, 32'h5);
    check("R2 pin_oe", pin_oe, 32'h00FF00FF);
    wr(32'hA1B2C3D4);
    check("R3 R4 pin_out", pin_out, 32'h00B200D4);
    cfg(4'b1111, 0);
    check("R4 ignored lanes", pin_out, 32'h00B200D4);
  endtask

  task automatic t_retain;
    wr(32'h11223344);
    check("R3 all out", pin_out, 32'h11223344);
    cfg(4'b0000, 0);
    check("R4 input zero", pin_out, 0);
    cfg(4'b1111, 0);
    check("R8 retained", pin_out, 32'h11223344);
    repeat (3) @(negedge clk);
    check("R8 stable", pin_out, 32'h11223344);
  endtask

  task automatic t_internal;
    logic [31:0] v;
    cfg(4'b0011, 0);
    pin_in = 32'hDEADBEEF;
    rd(v);
    check("R5 R7 mixed read", v, 32'hDEAD3344);
    pin_in = 32'h0;
    repeat (3) @(negedge clk);
    check("R5 hold", data_rdata, 32'hDEAD3344);
    rd(v);
    check("R5 resample", v, 32'h00003344);
  endtask

  task automatic t_external;
    logic [31:0] v;
    cfg(4'b0000, 1);
    check("R2 cfg_ext", {31'd0, cfg_ext}, 1);
    pin_in = 32'h55AA55AA;
    rd(v);
    check("R6 live pins ignored", v, 0);
    @(negedge clk); ext_strobe = 1;
    repeat (2) @(negedge clk); pin_in = 32'hCAFEF00D;
    @(negedge clk); pin_in = 32'h0BADBEEF;
    rd(v);
    check("R6 third edge", v, 32'hCAFEF00D);
    pin_in = 32'h12345678;
    repeat (5) @(negedge clk);
    rd(v);
    check("R6 steady strobe", v, 32'hCAFEF00D);
    ext_strobe = 0;
    repeat (5) @(negedge clk);
    rd(v);
    check("R6 falling strobe", v, 32'hCAFEF00D);
    cfg(4'b1100, 1);
    rd(v);
    check("R6 R7 ext mixed", v, 32'h1122F00D);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_dir_and_write();
    t_retain();
    t_internal();
    t_external();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule